// File: doc/BRIEF.md
# Register Producer-Tag Status Table

This block keeps, for every architectural register of an out-of-order core, the committed 32-bit value and a small producer tag. The tag names the in-flight station that will next write the register. A tag of zero means no write is pending. At issue, two source operands are looked up in the same cycle. Each lookup returns either a usable value or the tag of the producer the consumer must wait for. In that same cycle, the destination register of the issuing instruction is given the tag of its newly allocated station.

The table also listens to the result bus. A broadcast result lands in a register only when that register still names the broadcasting tag; the tag is then cleared. Because a later issue to the same register replaces the older tag, a slow, older writer that finishes late is simply dropped. This removes write-after-write stalls. Lookups see a same-cycle broadcast, so a consumer never misses a result that is on the bus while it issues.

Top module: `regstat_table`

## Requirements
- R1: A synchronous active-low reset sets every tag to zero and every value to zero, so every lookup afterwards returns ready with data 0.
- R2: A lookup of a register whose tag is zero returns ready=1, its stored value on the data output, and tag output 0, in the same cycle.
- R3: A lookup of a register with a nonzero tag that is not being broadcast returns ready=0, data 0, and that tag on the tag output.
- R4: When issue valid is high, the destination register's tag equals the issue tag from the next cycle on. The issue tag is always in the range 1 to 7.
- R5: A later issue to the same register replaces the older tag, and a later broadcast of the older tag leaves that register pending on the newer tag.
- R6: A valid broadcast whose tag equals a register's nonzero tag writes the broadcast data into that register and clears its tag from the next cycle on.
- R7: A lookup whose register tag equals the tag being validly broadcast in the same cycle returns ready=1 with the broadcast data and tag output 0.
- R8: When a register is renamed in the same cycle that its current tag is broadcast, the register takes the new tag and stays pending.
- R9: A broadcast with valid low, or with tag 0, changes no register.
- R10: Lookups return the state from before a same-cycle issue, so renaming a register does not change what a lookup of it returns in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a_idx | input | 4 | Register index for lookup A |
| src_a_ready | output | 1 | Lookup A operand is available |
| src_a_data | output | 32 | Lookup A operand value (0 when not ready) |
| src_a_tag | output | 3 | Lookup A producer tag (0 when ready) |
| src_b_idx | input | 4 | Register index for lookup B |
| src_b_ready | output | 1 | Lookup B operand is available |
| src_b_data | output | 32 | Lookup B operand value (0 when not ready) |
| src_b_tag | output | 3 | Lookup B producer tag (0 when ready) |
| iss_valid | input | 1 | Rename the destination this cycle |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 3 | Producer tag for the destination (nonzero) |
| rb_valid | input | 1 | Result bus carries a result |
| rb_tag | input | 3 | Tag of the broadcasting producer |
| rb_data | input | 32 | Broadcast result value |

## Verification
The bench targets several corner cases, each of which an incorrect table would handle in a visible way:
- A stale broadcast of an overridden tag: a table that drops the tag check would overwrite the register and report it ready too early.
- Rename and broadcast of the old tag in the same cycle: a table with the wrong priority would clear the new tag and lose the pending writer.
- A lookup that hits the tag currently on the bus: without the bypass, the table would return not-ready one cycle too long.
- Broadcasts with tag zero or with valid low: if these are not ignored, idle registers would be corrupted.
- Rename and lookup of the same register in one cycle: a table that forwards the rename would make an instruction wait on itself.

Random traffic steers most broadcast tags toward tags that are currently pending.

// File: rtl/regstat_pkg.sv
// Package: default sizing shared by the status table and its bench.
// Assumes tag value zero is reserved to mean "no pending producer".
package regstat_pkg;
    localparam int unsigned DEF_NREG = 16;
    localparam int unsigned DEF_DW   = 32;
    localparam int unsigned DEF_TW   = 3;
endpackage

// File: rtl/regstat_entry.sv
// One register of the status table: committed value plus producer tag.
// Assumes the rename tag is nonzero; a rename wins over a matching
// result-bus write for the tag field.
module regstat_entry #(
    parameter int unsigned DW = 32,
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic [TW-1:0] ren_tag,
    input  logic          rb_valid,
    input  logic [TW-1:0] rb_tag,
    input  logic [DW-1:0] rb_data,
    output logic [TW-1:0] qi,
    output logic [DW-1:0] val
);
    logic hit;

    // Purpose: detect a result-bus broadcast addressed to this register.
    always_comb begin
        hit = rb_valid && (qi != '0) && (qi == rb_tag);
    end

    // Purpose: update tag and value on reset, rename and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qi  <= '0;
            val <= '0;
        end else begin
            if (hit) begin
                val <= rb_data;
                if (!ren) qi <= '0;
            end
            if (ren) qi <= ren_tag;
        end
    end

    // R4: a rename is visible as the tag next cycle
    p_rename_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ren |=> (qi == $past(ren_tag)));

    // R6: matching broadcast without rename lands data and clears tag
    p_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ren) |=> (qi == '0 && val == $past(rb_data)));

    // R9: without rename or matching broadcast the entry holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && !hit) |=> ($stable(qi) && $stable(val)));
endmodule

// File: rtl/regstat_lookup.sv
// Source operand lookup: combinational read of tag/value with a bypass
// from the result bus. Assumes arrays reflect state before this cycle's edge.
module regstat_lookup #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 32,
    parameter int unsigned TW   = 3,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic [TW-1:0] qi_arr [NREG],
    input  logic [DW-1:0] val_arr [NREG],
    input  logic          rb_valid,
    input  logic [TW-1:0] rb_tag,
    input  logic [DW-1:0] rb_data,
    output logic          ready,
    output logic [DW-1:0] data,
    output logic [TW-1:0] tag
);
    logic [TW-1:0] q;

    // Purpose: select value, bypassed broadcast, or producer tag.
    always_comb begin
        q = qi_arr[idx];
        if (q == '0) begin
            ready = 1'b1;
            data  = val_arr[idx];
            tag   = '0;
        end else if (rb_valid && (q == rb_tag)) begin
            ready = 1'b1;
            data  = rb_data;
            tag   = '0;
        end else begin
            ready = 1'b0;
            data  = '0;
            tag   = q;
        end
    end

    // R3: a not-ready answer always names a real producer
    p_pending_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (tag != '0 && data == '0));

    // R7: a ready answer never carries a tag
    p_ready_notag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (tag == '0));
endmodule

// File: rtl/regstat_table.sv
// Register producer-tag status table: two lookups and one rename per
// cycle, result-bus write-back guarded by tag match. Assumes issue tags
// are nonzero and unique among in-flight producers.
module regstat_table #(
    parameter int unsigned NREG = regstat_pkg::DEF_NREG,
    parameter int unsigned DW   = regstat_pkg::DEF_DW,
    parameter int unsigned TW   = regstat_pkg::DEF_TW,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] src_a_idx,
    output logic          src_a_ready,
    output logic [DW-1:0] src_a_data,
    output logic [TW-1:0] src_a_tag,
    input  logic [IW-1:0] src_b_idx,
    output logic          src_b_ready,
    output logic [DW-1:0] src_b_data,
    output logic [TW-1:0] src_b_tag,
    input  logic          iss_valid,
    input  logic [IW-1:0] iss_dst,
    input  logic [TW-1:0] iss_tag,
    input  logic          rb_valid,
    input  logic [TW-1:0] rb_tag,
    input  logic [DW-1:0] rb_data
);
    logic [TW-1:0] qi_arr  [NREG];
    logic [DW-1:0] val_arr [NREG];

    // Purpose: one status entry per architectural register.
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic ren;
        always_comb ren = iss_valid && (iss_dst == IW'(g));
        regstat_entry #(.DW(DW), .TW(TW)) u_ent (
            .clk(clk), .rst_n(rst_n), .ren(ren), .ren_tag(iss_tag),
            .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data),
            .qi(qi_arr[g]), .val(val_arr[g])
        );
    end

    regstat_lookup #(.NREG(NREG), .DW(DW), .TW(TW)) u_look_a (
        .clk(clk), .rst_n(rst_n), .idx(src_a_idx),
        .qi_arr(qi_arr), .val_arr(val_arr),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data),
        .ready(src_a_ready), .data(src_a_data), .tag(src_a_tag)
    );

    regstat_lookup #(.NREG(NREG), .DW(DW), .TW(TW)) u_look_b (
        .clk(clk), .rst_n(rst_n), .idx(src_b_idx),
        .qi_arr(qi_arr), .val_arr(val_arr),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data),
        .ready(src_b_ready), .data(src_b_data), .tag(src_b_tag)
    );

    // R4: issue never presents the reserved zero tag
    p_issue_tag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_tag != '0));

    // R8: rename of the destination wins over its broadcast in the same cycle
    p_rename_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && rb_valid && qi_arr[iss_dst] == rb_tag && rb_tag != '0)
        |=> (qi_arr[$past(iss_dst)] == $past(iss_tag)));
endmodule

// File: tb/regstat_table_tb.sv
// Bench: directed corner cases then seeded random traffic, checked
// against a behavioural model kept in bench arrays.
module regstat_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int DW = 32;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    src_a_idx = '0, src_b_idx = '0, iss_dst = '0;
    logic          src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_data, src_b_data;
    logic [TW-1:0] src_a_tag, src_b_tag;
    logic          iss_valid = 1'b0, rb_valid = 1'b0;
    logic [TW-1:0] iss_tag = '0, rb_tag = '0;
    logic [DW-1:0] rb_data = '0;

    int n_checks = 0;
    int n_errors = 0;
    logic [TW-1:0] m_qi  [NREG];
    logic [DW-1:0] m_val [NREG];

    regstat_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_data(src_a_data), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_data(src_b_data), .src_b_tag(src_b_tag),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW+TW:0] expect_of(input int idx);
        logic [TW-1:0] q = m_qi[idx];
        if (q == '0) return {1'b1, m_val[idx], {TW{1'b0}}};
        if (rb_valid && q == rb_tag) return {1'b1, rb_data, {TW{1'b0}}};
        return {1'b0, {DW{1'b0}}, q};
    endfunction

    task automatic check_port(input string req, input string nm, input logic [DW+TW:0] act, input logic [DW+TW:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s port %s: actual rdy=%0b data=%h tag=%0d expected rdy=%0b data=%h tag=%0d",
                     req, nm, act[DW+TW], act[DW+TW-1:TW], act[TW-1:0],
                     exp[DW+TW], exp[DW+TW-1:TW], exp[TW-1:0]);
        end
    endtask

    task automatic step(input int ia, input int ib, input logic iv, input int id, input int it,
                        input logic cv, input int ct, input logic [DW-1:0] cd, input string req);
        @(negedge clk);
        src_a_idx = 4'(ia); src_b_idx = 4'(ib);
        iss_valid = iv; iss_dst = 4'(id); iss_tag = TW'(it);
        rb_valid = cv; rb_tag = TW'(ct); rb_data = cd;
        #1;
        check_port(req, "A", {src_a_ready, src_a_data, src_a_tag}, expect_of(ia));
        check_port(req, "B", {src_b_ready, src_b_data, src_b_tag}, expect_of(ib));
        @(posedge clk);
        for (int r = 0; r < NREG; r++) begin
            if (cv && m_qi[r] != '0 && m_qi[r] == TW'(ct)) begin
                m_val[r] = cd;
                m_qi[r] = '0;
            end
        end
        if (iv) m_qi[id] = TW'(it);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int r = 0; r < NREG; r++) begin m_qi[r] = '0; m_val[r] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state visible on both lookups
        step(0, 15, 0, 0, 0, 0, 0, 0, "R1");
        // R4: rename r3 to tag 5, observed next cycle (R3 pending answer)
        step(1, 2, 1, 3, 5, 0, 0, 0, "R4");
        step(3, 3, 0, 0, 0, 0, 0, 0, "R3");
        // R5: override with tag 6, then stale broadcast of tag 5
        step(3, 3, 1, 3, 6, 0, 0, 0, "R5");
        step(3, 3, 0, 0, 0, 1, 5, 32'hdead_0005, "R5");
        step(3, 3, 0, 0, 0, 0, 0, 0, "R5");
        // R7: bypass on same-cycle broadcast; R6: value lands next cycle
        step(3, 4, 0, 0, 0, 1, 6, 32'hcafe_0006, "R7");
        step(3, 3, 0, 0, 0, 0, 0, 0, "R6");
        // R8: rename r4 while its old tag broadcasts
        step(4, 4, 1, 4, 2, 0, 0, 0, "R8");
        step(4, 5, 1, 4, 3, 1, 2, 32'h1111_2222, "R8");
        step(4, 4, 0, 0, 0, 0, 0, 0, "R8");
        // R9: invalid broadcast and tag-zero broadcast are ignored
        step(4, 0, 0, 0, 0, 0, 3, 32'h3333_3333, "R9");
        step(4, 0, 0, 0, 0, 1, 0, 32'h4444_4444, "R9");
        step(4, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R10: lookup of a register renamed in the same cycle
        step(3, 3, 1, 3, 1, 0, 0, 0, "R10");
        step(3, 3, 0, 0, 0, 0, 0, 0, "R10");
        // random traffic, broadcasts biased to pending tags (R2 R3 R6 R7)
        for (int i = 0; i < 600; i++) begin
            int ct;
            int pick = int'($urandom_range(NREG-1));
            if ($urandom_range(9) < 7) ct = int'(m_qi[pick]);
            else ct = int'($urandom_range(7));
            step(int'($urandom_range(NREG-1)), int'($urandom_range(NREG-1)),
                 1'($urandom_range(1)), int'($urandom_range(NREG-1)), int'($urandom_range(7, 1)),
                 1'($urandom_range(3) != 0), ct, $urandom(), "R2_R3_R6_R7_random");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule